// File: doc/BRIEF.md
# DAC SPI Configuration and Readback Sequencer

This block is an SPI master that sets up a four-channel bipolar DAC and then confirms the setup by reading a register back. After a start pulse it sends five 24-bit command frames in a fixed order. The first powers up all four channels, the second selects the ±5 V output range for every channel, and the third loads one code into all channel registers at once. The fourth asks to read the power-control register. The fifth is a no-op, and the slave returns the requested register during it.

Frames go out MSB first under an active-low select. The serial clock idles low and runs at a rate derived from the system clock. Data changes on the rising clock edge so that a slave sampling on the falling edge sees stable bits. The reply is captured on falling edges during the no-op frame only. Its low 16 bits are compared with the data sent in the power-up frame, and the result sets a mismatch flag. An input chosen at start decides whether the power-up frame also turns on the DAC's internal reference.

Top module: `dac_cfg_seq`

## Requirements
- R1: After reset cs_n is 1, sclk, mosi, busy, done and mismatch are 0, and rb_word is zero.
- R2: A start pulse while idle produces exactly five frames, in this order: power-up 0x10000F (bit 4 set as well when the reference option is on), range 0x0C0003, code 0x04FFFF, read request 0x900000, no-op 0x180000.
- R3: Each frame has exactly 24 sclk pulses. cs_n stays low from before the first rising edge until after the last falling edge, and bits are sent MSB first.
- R4: mosi changes only on a rising sclk edge or when cs_n goes high, so mosi is stable at every falling edge.
- R5: sclk is high for CLK_HZ/(2·SCLK_HZ) system clocks and low for the same number; the default parameters give 5 MHz from 250 MHz.
- R6: cs_n stays high for at least GAP_SCLK sclk periods between frames, and sclk is low whenever cs_n is high.
- R7: use_int_ref is sampled when start is accepted. If it is 1, bit 4 (reference enable) of the power-up data field is set, giving 0x10001F. Changing it during a sequence has no effect on that sequence.
- R8: The bits on miso are captured on falling sclk edges during the no-op frame only, MSB first, into a 24-bit word. rb_word takes this word in the cycle done rises and holds it otherwise.
- R9: mismatch equals (rb_word[15:0] != power-up data field). It is valid while done is high and is 0 otherwise.
- R10: busy rises in the cycle after start is accepted and falls in the cycle done rises. done stays high until the next accepted start, and busy and done are never high together.
- R11: A start pulse while busy is ignored. The sequence continues unchanged and still sends exactly five frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins the configure-and-verify script |
| use_int_ref | input | 1 | When 1, the power-up frame also enables the internal reference |
| miso | input | 1 | Serial data from the DAC |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low frame select |
| mosi | output | 1 | Serial data to the DAC |
| rb_word | output | 24 | Word captured during the no-op frame |
| busy | output | 1 | Script in progress |
| done | output | 1 | Script finished; held until the next start |
| mismatch | output | 1 | Readback data differs from the power-up data |

## Verification
The bench builds the block with CLK_HZ set to 30 MHz and keeps SCLK_HZ at 5 MHz and GAP_SCLK at 2. This gives a half period of three system clocks and a 12-cycle gap between frames. At these values a full five-frame script takes about 800 cycles, so the bench can run several scripts and compare every sclk edge, every select window and every busy/done transition against a timeline it computes from start. The bench acts as the slave: it drives junk on miso during the first four frames and a chosen, optionally corrupted, reply during the no-op frame. This exercises the capture window, both reference settings and the mismatch path.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;

  localparam int FRAME_W   = 24;
  localparam int NUM_STEPS = 5;
  localparam int DATA_W    = 16;

  typedef logic [FRAME_W-1:0] frame_t;

  // register select field, bits [21:19]
  localparam logic [2:0] RS_CODE  = 3'b000;
  localparam logic [2:0] RS_RANGE = 3'b001;
  localparam logic [2:0] RS_PWR   = 3'b010;
  localparam logic [2:0] RS_CTRL  = 3'b011;

  // channel address field, bits [18:16]
  localparam logic [2:0] CH_NONE  = 3'b000;
  localparam logic [2:0] CH_ALL   = 3'b100;

  // bit of the power data field that turns on the internal reference
  localparam int PWR_REF_BIT = 4;

  function automatic frame_t make_frame(input logic rd, input logic [2:0] rsel,
                                        input logic [2:0] chan,
                                        input logic [DATA_W-1:0] data);
    return {rd, 1'b0, rsel, chan, data};
  endfunction

endpackage

// File: rtl/dac_cfg_script.sv
module dac_cfg_script
  import dac_seq_pkg::*;
#(
  parameter logic [3:0]        CH_MASK   = 4'hF,
  parameter logic [2:0]        RANGE_SEL = 3'd3,
  parameter logic [DATA_W-1:0] DAC_CODE  = 16'hFFFF
) (
  input  logic              use_ref,
  input  logic [2:0]        step,
  output frame_t            frame,
  output logic [DATA_W-1:0] pwr_data
);

  frame_t tbl [NUM_STEPS];

  assign pwr_data = DATA_W'(CH_MASK) |
                    (use_ref ? DATA_W'(1 << PWR_REF_BIT) : '0);

  // one table entry per step of the script
  for (genvar i = 0; i < NUM_STEPS; i++) begin : g_tbl
    if (i == 0) begin : g_pwr
      assign tbl[i] = make_frame(1'b0, RS_PWR, CH_NONE, pwr_data);
    end else if (i == 1) begin : g_rng
      assign tbl[i] = make_frame(1'b0, RS_RANGE, CH_ALL, DATA_W'(RANGE_SEL));
    end else if (i == 2) begin : g_code
      assign tbl[i] = make_frame(1'b0, RS_CODE, CH_ALL, DAC_CODE);
    end else if (i == 3) begin : g_rd
      assign tbl[i] = make_frame(1'b1, RS_PWR, CH_NONE, '0);
    end else begin : g_nop
      assign tbl[i] = make_frame(1'b0, RS_CTRL, CH_NONE, '0);
    end
  end

  assign frame = (int'(step) < NUM_STEPS) ? tbl[step] : '0;

endmodule

// File: rtl/spi_frame_xfer.sv
module spi_frame_xfer
  import dac_seq_pkg::*;
#(
  parameter int HALF_DIV = 25,
  parameter int GAP_CYC  = 100
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   go,
  input  frame_t tx,
  input  logic   miso,
  output logic   sclk,
  output logic   cs_n,
  output logic   mosi,
  output frame_t rx,
  output logic   rdy
);

  localparam int CNT_MAX = (HALF_DIV > GAP_CYC) ? HALF_DIV : GAP_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int BIT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF_DIV - 1);
  localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(GAP_CYC - 1);
  localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(FRAME_W - 1);

  typedef enum logic [2:0] {X_IDLE, X_LEAD, X_HI, X_LO, X_GAP} xst_e;

  xst_e             st;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bitc;
  frame_t           sh;

  always_ff @(posedge clk) begin
    rdy <= 1'b0;
    if (rst) begin
      st   <= X_IDLE;
      cnt  <= '0;
      bitc <= '0;
      sh   <= '0;
      rx   <= '0;
      sclk <= 1'b0;
      cs_n <= 1'b1;
      mosi <= 1'b0;
    end else begin
      case (st)
        X_IDLE: if (go) begin
          cs_n <= 1'b0;
          sh   <= tx;
          rx   <= '0;
          cnt  <= '0;
          bitc <= '0;
          st   <= X_LEAD;
        end
        X_LEAD: if (cnt == HALF_LAST) begin
          cnt  <= '0;
          sclk <= 1'b1;
          mosi <= sh[FRAME_W-1];
          sh   <= {sh[FRAME_W-2:0], 1'b0};
          st   <= X_HI;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
        X_HI: if (cnt == HALF_LAST) begin
          cnt  <= '0;
          sclk <= 1'b0;
          rx   <= {rx[FRAME_W-2:0], miso};
          st   <= X_LO;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
        X_LO: if (cnt == HALF_LAST) begin
          cnt <= '0;
          if (bitc == BIT_LAST) begin
            cs_n <= 1'b1;
            mosi <= 1'b0;
            st   <= X_GAP;
          end else begin
            sclk <= 1'b1;
            mosi <= sh[FRAME_W-1];
            sh   <= {sh[FRAME_W-2:0], 1'b0};
            bitc <= bitc + BIT_W'(1);
            st   <= X_HI;
          end
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
        X_GAP: if (cnt == GAP_LAST) begin
          cnt <= '0;
          rdy <= 1'b1;
          st  <= X_IDLE;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
        default: st <= X_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dac_seq_ctrl.sv
module dac_seq_ctrl
  import dac_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              use_int_ref,
  input  logic              xfer_rdy,
  input  frame_t            rx_word,
  input  logic [DATA_W-1:0] pwr_data,
  output logic              go,
  output logic [2:0]        step,
  output logic              ref_q,
  output logic              busy,
  output logic              done,
  output logic              mismatch,
  output frame_t            rb_word
);

  localparam logic [2:0] STEP_LAST = 3'(NUM_STEPS - 1);

  always_ff @(posedge clk) begin
    go <= 1'b0;
    if (rst) begin
      step     <= '0;
      ref_q    <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      mismatch <= 1'b0;
      rb_word  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy     <= 1'b1;
        done     <= 1'b0;
        mismatch <= 1'b0;
        step     <= '0;
        ref_q    <= use_int_ref;
        go       <= 1'b1;
      end
    end else if (xfer_rdy) begin
      if (step == STEP_LAST) begin
        busy     <= 1'b0;
        done     <= 1'b1;
        rb_word  <= rx_word;
        mismatch <= (rx_word[DATA_W-1:0] != pwr_data);
      end else begin
        step <= step + 3'd1;
        go   <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/dac_cfg_seq.sv
module dac_cfg_seq
  import dac_seq_pkg::*;
#(
  parameter int                CLK_HZ    = 250_000_000,
  parameter int                SCLK_HZ   = 5_000_000,
  parameter int                GAP_SCLK  = 2,
  parameter logic [3:0]        CH_MASK   = 4'hF,
  parameter logic [2:0]        RANGE_SEL = 3'd3,
  parameter logic [DATA_W-1:0] DAC_CODE  = 16'hFFFF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               use_int_ref,
  input  logic               miso,
  output logic               sclk,
  output logic               cs_n,
  output logic               mosi,
  output logic [FRAME_W-1:0] rb_word,
  output logic               busy,
  output logic               done,
  output logic               mismatch
);

  localparam int HALF_DIV = CLK_HZ / (2 * SCLK_HZ);
  localparam int GAP_CYC  = GAP_SCLK * 2 * HALF_DIV;

  logic              go, xfer_rdy, ref_q;
  logic [2:0]        step;
  frame_t            tx_frame, rx_word;
  logic [DATA_W-1:0] pwr_data;

  dac_cfg_script #(
    .CH_MASK  (CH_MASK),
    .RANGE_SEL(RANGE_SEL),
    .DAC_CODE (DAC_CODE)
  ) u_script (
    .use_ref (ref_q),
    .step    (step),
    .frame   (tx_frame),
    .pwr_data(pwr_data)
  );

  dac_seq_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .use_int_ref(use_int_ref),
    .xfer_rdy   (xfer_rdy),
    .rx_word    (rx_word),
    .pwr_data   (pwr_data),
    .go         (go),
    .step       (step),
    .ref_q      (ref_q),
    .busy       (busy),
    .done       (done),
    .mismatch   (mismatch),
    .rb_word    (rb_word)
  );

  spi_frame_xfer #(
    .HALF_DIV(HALF_DIV),
    .GAP_CYC (GAP_CYC)
  ) u_xfer (
    .clk (clk),
    .rst (rst),
    .go  (go),
    .tx  (tx_frame),
    .miso(miso),
    .sclk(sclk),
    .cs_n(cs_n),
    .mosi(mosi),
    .rx  (rx_word),
    .rdy (xfer_rdy)
  );

endmodule

// File: rtl/dac_cfg_seq_chk.sv
module dac_cfg_seq_chk #(
  parameter int HALF_DIV = 25
) (
  input logic        clk,
  input logic        rst,
  input logic        sclk,
  input logic        cs_n,
  input logic        mosi,
  input logic        busy,
  input logic        done,
  input logic        mismatch,
  input logic [23:0] rb_word
);

  int hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)       hi_cnt <= 0;
    else if (sclk) hi_cnt <= hi_cnt + 1;
    else           hi_cnt <= 0;
  end

  // R6
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst) cs_n |-> !sclk);

  // R3
  sclk_in_frame_chk: assert property (@(posedge clk) disable iff (rst) $rose(sclk) |-> !cs_n);

  // R4
  mosi_hold_chk: assert property (@(posedge clk) disable iff (rst) $fell(sclk) |-> $stable(mosi));

  // R5
  sclk_high_len_chk: assert property (@(posedge clk) disable iff (rst) $fell(sclk) |-> hi_cnt == HALF_DIV);

  // R10
  busy_done_chk: assert property (@(posedge clk) disable iff (rst) busy |-> !done);

  // R9
  mismatch_done_chk: assert property (@(posedge clk) disable iff (rst) mismatch |-> done);

  // R8
  rb_hold_chk: assert property (@(posedge clk) disable iff (rst) !$rose(done) |-> $stable(rb_word));

endmodule

bind dac_cfg_seq dac_cfg_seq_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .sclk    (sclk),
  .cs_n    (cs_n),
  .mosi    (mosi),
  .busy    (busy),
  .done    (done),
  .mismatch(mismatch),
  .rb_word (rb_word)
);

// File: tb/tb_dac_cfg_seq.sv
module tb_dac_cfg_seq;

  localparam int H    = 3;
  localparam int GAPS = 2;
  localparam int G    = GAPS * 2 * H;
  localparam int FL   = 49 * H;            // cycles cs_n stays low
  localparam int P    = FL + G + 2;        // frame-to-frame spacing
  localparam int TEND = 2 + 4 * P + FL + G;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        use_int_ref = 1'b0;
  logic        miso;
  logic        sclk, cs_n, mosi, busy, done, mismatch;
  logic [23:0] rb_word;

  dac_cfg_seq #(.CLK_HZ(30_000_000), .SCLK_HZ(5_000_000), .GAP_SCLK(GAPS)) dut (
    .clk(clk), .rst(rst), .start(start), .use_int_ref(use_int_ref), .miso(miso),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .rb_word(rb_word),
    .busy(busy), .done(done), .mismatch(mismatch)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // ---------------- reference model state ----------------
  bit          have_run = 0;
  int          e0 = 0;
  bit          run_ref = 0;
  logic [15:0] corrupt = 16'h0;
  logic [23:0] cur_rb = '0, prev_rb = '0;
  bit          cur_mis = 0, prev_mis = 0, prev_done = 0;

  function automatic logic [23:0] exp_frame(input int f, input bit r);
    case (f)
      0: return 24'h10000F | (r ? 24'h000010 : 24'h0);
      1: return 24'h0C0003;
      2: return 24'h04FFFF;
      3: return 24'h900000;
      default: return 24'h180000;
    endcase
  endfunction

  // per-clock comparison against the behavioural timeline
  int m_rel, m_d;
  bit e_cs, e_sclk, e_busy, e_done, e_mis;
  logic [23:0] e_rb;

  always @(negedge clk) begin
    if (!rst) begin
      m_rel = cyc - e0;
      e_cs = 1; e_sclk = 0;
      if (!have_run || m_rel < 0) begin
        e_busy = 0; e_done = prev_done; e_mis = prev_mis; e_rb = prev_rb;
      end else if (m_rel >= TEND) begin
        e_busy = 0; e_done = 1; e_mis = cur_mis; e_rb = cur_rb;
      end else begin
        e_busy = 1; e_done = 0; e_mis = 0; e_rb = prev_rb;
        for (int f = 0; f < 5; f++) begin
          m_d = m_rel - (1 + f * P);
          if (m_d >= 0 && m_d < FL) begin
            e_cs = 0;
            if (((m_d / H) % 2) == 1) e_sclk = 1;
          end
        end
      end
      chk(cs_n == e_cs, "R6", "cs_n", 32'(cs_n), 32'(e_cs));
      chk(sclk == e_sclk, "R5", "sclk", 32'(sclk), 32'(e_sclk));
      chk(busy == e_busy, "R10", "busy", 32'(busy), 32'(e_busy));
      chk(done == e_done, "R10", "done", 32'(done), 32'(e_done));
      chk(mismatch == e_mis, "R9", "mismatch", 32'(mismatch), 32'(e_mis));
      chk(rb_word == e_rb, "R8", "rb_word", 32'(rb_word), 32'(e_rb));
    end
  end

  // ---------------- slave model ----------------
  bit          s_prev_sclk = 0, s_prev_cs = 1;
  int          s_rises = 0, s_bits = 0, frame_idx = 0;
  logic [23:0] s_rx = '0, s_reply = '0;
  logic [15:0] s_pwr = '0;

  always @(negedge clk) begin
    if (rst) begin
      miso = 1'b0;
      s_prev_sclk = 0; s_prev_cs = 1;
    end else begin
      if (s_prev_cs && !cs_n) begin
        s_rises = 0; s_bits = 0; s_rx = '0;
        s_reply = (frame_idx == 4) ? {8'h10, s_pwr ^ corrupt} : (24'h5A3C00 | 24'(frame_idx));
      end
      if (!cs_n && !s_prev_sclk && sclk) begin
        if (s_rises < 24) miso = s_reply[23 - s_rises];
        s_rises++;
      end
      if (!cs_n && s_prev_sclk && !sclk) begin
        s_rx = {s_rx[22:0], mosi};
        s_bits++;
      end
      if (!s_prev_cs && cs_n) begin
        // R3: 24 bits per frame, MSB first; R2/R7: frame content and order
        chk(s_bits == 24, "R3", "bits per frame", 32'(s_bits), 32'd24);
        chk(s_rx == exp_frame(frame_idx, run_ref), "R2", "frame word",
            32'(s_rx), 32'(exp_frame(frame_idx, run_ref)));
        if (s_rx[23:16] == 8'h10) s_pwr = s_rx[15:0];
        frame_idx++;
        miso = 1'b0;
      end
      s_prev_sclk = sclk;
      s_prev_cs = cs_n;
    end
  end

  task automatic pulse_start(input bit r, input logic [15:0] corr);
    @(negedge clk);
    start = 1'b1;
    use_int_ref = r;
    if (!have_run || (cyc - e0) >= TEND) begin
      prev_done = have_run; prev_rb = cur_rb; prev_mis = cur_mis;
      e0 = cyc + 1;
      have_run = 1;
      run_ref = r;
      corrupt = corr;
      frame_idx = 0;
      cur_rb = {8'h10, (16'h000F | (r ? 16'h0010 : 16'h0)) ^ corr};
      cur_mis = (corr != 16'h0);
    end
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end();
    while ((cyc - e0) < TEND + 4) @(negedge clk);
  endtask

  // watchdog
  initial begin
    #(4 * 200000);
    n_fail++;
    n_chk++;
    $display("FAIL R2 watchdog: cycle %0d expected completion before 200000", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(cs_n == 1'b1 && sclk == 1'b0 && mosi == 1'b0, "R1", "serial idle",
        {29'b0, cs_n, sclk, mosi}, 32'h4);
    chk(!busy && !done && !mismatch && rb_word == '0, "R1", "flags/rb",
        {busy, done, mismatch, 5'b0, rb_word}, 32'h0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // run A: external reference, clean reply
    pulse_start(1'b0, 16'h0);
    wait_end();
    chk(frame_idx == 5, "R2", "frame count", 32'(frame_idx), 32'd5);
    chk(rb_word == 24'h10000F, "R8", "readback", 32'(rb_word), 32'h10000F);
    chk(mismatch == 1'b0, "R9", "mismatch clean", 32'(mismatch), 32'h0);

    // run B: internal reference; R7 input changed mid-run, R11 second start ignored
    pulse_start(1'b1, 16'h0);
    repeat (40) @(negedge clk);
    use_int_ref = 1'b0;
    repeat (160) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_end();
    chk(frame_idx == 5, "R11", "frame count after ignored start", 32'(frame_idx), 32'd5);
    chk(rb_word == 24'h10001F, "R7", "readback with ref on", 32'(rb_word), 32'h10001F);

    // R10: done holds while idle
    repeat (50) @(negedge clk);
    chk(done == 1'b1 && busy == 1'b0, "R10", "done held", {30'b0, done, busy}, 32'h2);

    // run C: corrupted reply sets mismatch
    pulse_start(1'b0, 16'h0004);
    wait_end();
    chk(mismatch == 1'b1, "R9", "mismatch corrupt", 32'(mismatch), 32'h1);
    chk(rb_word == 24'h10000B, "R8", "readback corrupt", 32'(rb_word), 32'h10000B);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule